// File: doc/BRIEF.md
# Keyed Reset Sequence Detector

This block sits beside the write port of a register file. It watches writes to one key register and raises a request for a hardware reset only after the key register has received a fixed run of eight values. The run is a staircase of low-order ones that starts at 0x00 and ends at 0x7F. Any write to a different register of the same block breaks the run. So does a wrong value. A value of zero always starts the run again at its first step, so software can resynchronise at any point.

The block does not reset anything itself. Its output is a one-cycle request pulse. Downstream logic turns that pulse into the real system reset and handles any clock-domain crossing. Reads of the key register always return zero and have no effect on the run.

Top module: `keyed_reset_detector`

## Requirements
- R1: After the system reset, the request output is low, all earlier progress is forgotten, and only a fresh run starting at 0x00 can produce a request.
- R2: Eight key-register writes carrying the values 0x00, 0x01, 0x03, 0x07, 0x0F, 0x1F, 0x3F and 0x7F, in that order, produce a request. Step k (counting from 0) expects the value (1<<k)-1. The request is high in the clock cycle that follows the edge at which the eighth write is taken.
- R3: The request lasts exactly one cycle. The detector is then idle, so writing 0x01 through 0x7F without a leading 0x00 produces no request.
- R4: A write to any other register of the block (`wr_en`=1, `wr_is_key`=0) aborts the run in progress.
- R5: A key write of 0x00 always sets the progress to "first step done", at any point in the run, even when it is repeated.
- R6: A key write of a non-zero value that is not the next expected value returns the detector to idle. This includes a non-zero first write.
- R7: `rd_data` always reads zero, and a read (`rd_en`=1) between steps does not disturb the run.
- R8: Cycles without any write leave the progress unchanged, however many there are.
- R9: Once a request has been issued, a new complete run produces a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, synchronous |
| wr_en | input | 1 | Write strobe of the register block |
| wr_is_key | input | 1 | 1 when the write targets the key register, 0 for any other register |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe for the key register |
| rd_data | output | 8 | Read data of the key register (always zero) |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The detector is driven with a clean full run, run back to back twice, and then with a tail of the run that lacks its leading zero. Together these separate a correct one-cycle pulse from a pulse that sticks or a detector that stays armed. Broken runs are built by inserting three kinds of disturbance at different step positions: a foreign-register write, a wrong non-zero value, and a mid-run zero. Of these, only the zero may lead to a request, and only when the whole run is then written again after it. Runs interleaved with key reads, with long idle gaps, and with a system reset in the middle show which events the progress counter must ignore and which must clear it.

// File: rtl/kr_pkg.sv
package kr_pkg;

   // classification of one bus cycle as seen by the detector
   typedef enum logic [2:0] {
      KR_IDLE    = 3'd0,   // no write this cycle
      KR_FOREIGN = 3'd1,   // write to another register of the block
      KR_ZERO    = 3'd2,   // key write of zero: restart
      KR_MATCH   = 3'd3,   // key write of the expected next value
      KR_MISS    = 3'd4    // key write of any other value
   } kr_kind_e;

endpackage

// File: rtl/kr_key_table.sv
// Expected key value for every step: step k expects (1<<k)-1.
module kr_key_table #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_STEPS = 8,
   localparam int unsigned STEP_W   = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
   input  logic [STEP_W-1:0] step,
   output logic [DATA_W-1:0] exp_val
);

   logic [DATA_W-1:0] key_tab [NUM_STEPS];

   for (genvar g = 0; g < NUM_STEPS; g++) begin : g_key
      localparam longint unsigned ONES = (64'd1 << g) - 64'd1;
      assign key_tab[g] = ONES[DATA_W-1:0];
   end

   always_comb begin
      exp_val = '0;
      for (int i = 0; i < NUM_STEPS; i++) begin
         if (step == STEP_W'(i)) exp_val = key_tab[i];
      end
   end

endmodule

// File: rtl/kr_wr_classify.sv
// Sorts the current bus cycle into one of the detector's event kinds.
module kr_wr_classify
   import kr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              wr_en,
   input  logic              wr_is_key,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] exp_val,
   output kr_kind_e          kind
);

   always_comb begin
      if (!wr_en)                kind = KR_IDLE;
      else if (!wr_is_key)       kind = KR_FOREIGN;
      else if (wr_data == '0)    kind = KR_ZERO;
      else if (wr_data == exp_val) kind = KR_MATCH;
      else                       kind = KR_MISS;
   end

endmodule

// File: rtl/kr_step_ctrl.sv
// Progress counter: number of correct key writes seen so far.
module kr_step_ctrl
   import kr_pkg::*;
#(
   parameter int unsigned NUM_STEPS = 8,
   localparam int unsigned STEP_W   = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1,
   localparam int unsigned LAST     = NUM_STEPS - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  kr_kind_e          kind,
   output logic [STEP_W-1:0] step,
   output logic              fire
);

   logic [STEP_W-1:0] step_nxt;

   always_comb begin
      fire     = 1'b0;
      step_nxt = step;
      unique case (kind)
         KR_IDLE:    step_nxt = step;
         KR_FOREIGN: step_nxt = '0;
         KR_MISS:    step_nxt = '0;
         KR_ZERO: begin
            if (NUM_STEPS == 1) begin
               fire     = 1'b1;
               step_nxt = '0;
            end else begin
               step_nxt = STEP_W'(1);
            end
         end
         KR_MATCH: begin
            if (step == STEP_W'(LAST)) begin
               fire     = 1'b1;
               step_nxt = '0;
            end else begin
               step_nxt = step + STEP_W'(1);
            end
         end
         default: step_nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) step <= '0;
      else        step <= step_nxt;
   end

   // R8: no write means no movement
   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == KR_IDLE) |=> $stable(step));

endmodule

// File: rtl/keyed_reset_detector.sv
module keyed_reset_detector
   import kr_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_STEPS = 8,
   localparam int unsigned STEP_W   = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_is_key,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rst_req
);

   localparam longint unsigned LAST_ONES = (64'd1 << (NUM_STEPS - 1)) - 64'd1;
   localparam logic [DATA_W-1:0] LAST_KEY = LAST_ONES[DATA_W-1:0];

   // elaboration-time parameter checks
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("keyed_reset_detector: DATA_W must be 1..32");
   end
   if (NUM_STEPS < 2 || NUM_STEPS > DATA_W + 1) begin : g_bad_steps
      $error("keyed_reset_detector: NUM_STEPS must be 2..DATA_W+1");
   end

   logic [STEP_W-1:0] step;
   logic [DATA_W-1:0] exp_val;
   kr_kind_e          kind;
   logic              fire;
   logic              req_q;

   kr_key_table #(.DATA_W(DATA_W), .NUM_STEPS(NUM_STEPS)) u_table (
      .step    (step),
      .exp_val (exp_val)
   );

   kr_wr_classify #(.DATA_W(DATA_W)) u_class (
      .wr_en     (wr_en),
      .wr_is_key (wr_is_key),
      .wr_data   (wr_data),
      .exp_val   (exp_val),
      .kind      (kind)
   );

   kr_step_ctrl #(.NUM_STEPS(NUM_STEPS)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .kind  (kind),
      .step  (step),
      .fire  (fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= fire;
   end

   assign rst_req = req_q;
   // the key register has no readable content
   assign rd_data = {DATA_W{1'b0}} & {DATA_W{rd_en}};

   // R2: a request is always caused by a final key write one edge earlier
   assert_req_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(wr_en && wr_is_key && wr_data == LAST_KEY));

   // R3: request is a single-cycle pulse
   assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R4: foreign write clears progress
   assert_foreign_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_is_key) |=> (step == '0));

   // R5: zero key write restarts at first step
   assert_zero_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_is_key && wr_data == '0) |=> (step == STEP_W'(1)));

   // R6: wrong non-zero key value drops to idle
   assert_miss_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_is_key && wr_data != '0 && wr_data != exp_val) |=> (step == '0));

   // R7: read data never carries content
   always_comb begin
      assert_read_zero_R7: assert (!rd_en || rd_data == '0);
   end

endmodule

// File: tb/sim_keyed_reset_detector.sv
module sim_keyed_reset_detector;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_is_key = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rst_req;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   keyed_reset_detector u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_key(wr_is_key),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rst_req(rst_req)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] key_of(input int k);
      return 8'((1 << k) - 1);
   endfunction

   // one key write; returns rst_req in the cycle after the write edge
   task automatic key_wr(input logic [7:0] v, output logic p);
      @(negedge clk);
      wr_en = 1'b1; wr_is_key = 1'b1; wr_data = v;
      @(negedge clk);
      p = rst_req;
      wr_en = 1'b0; wr_is_key = 1'b0; wr_data = '0;
   endtask

   task automatic other_wr();
      @(negedge clk);
      wr_en = 1'b1; wr_is_key = 1'b0; wr_data = 8'h00;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // write steps first..last-1; count pulses seen
   task automatic steps(input int first, input int last, output int pulses);
      logic p;
      pulses = 0;
      for (int k = first; k < last; k++) begin
         key_wr(key_of(k), p);
         if (p) pulses++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      int n;
      check("R1 reset request low", {7'd0, rst_req}, 8'd0);
      steps(0, 4, n);
      do_reset();
      check("R1 request low after reset", {7'd0, rst_req}, 8'd0);
      steps(4, 8, n);
      check("R1 progress forgotten", 8'(n), 8'd0);
   endtask

   task automatic t_full();
      logic p;
      int n;
      steps(0, 7, n);
      check("R2 no early request", 8'(n), 8'd0);
      key_wr(key_of(7), p);
      check("R2 request after eighth write", {7'd0, p}, 8'd1);
      @(negedge clk);
      check("R3 request one cycle", {7'd0, rst_req}, 8'd0);
      steps(1, 8, n);
      check("R3 idle after request", 8'(n), 8'd0);
   endtask

   task automatic t_repeat();
      int a, b;
      steps(0, 8, a);
      steps(0, 8, b);
      check("R9 first run", 8'(a), 8'd1);
      check("R9 second run", 8'(b), 8'd1);
   endtask

   task automatic t_foreign();
      int n;
      steps(0, 4, n);
      other_wr();
      steps(4, 8, n);
      check("R4 foreign write aborts", 8'(n), 8'd0);
      steps(0, 7, n);
      other_wr();
      steps(7, 8, n);
      check("R4 abort before last step", 8'(n), 8'd0);
   endtask

   task automatic t_zero();
      logic p;
      int n;
      steps(0, 5, n);
      key_wr(8'h00, p);
      steps(1, 8, n);
      check("R5 zero restarts mid run", 8'(n), 8'd1);
      key_wr(8'h00, p);
      key_wr(8'h00, p);
      steps(1, 8, n);
      check("R5 repeated zero", 8'(n), 8'd1);
   endtask

   task automatic t_wrong();
      logic p;
      int n;
      steps(0, 3, n);
      key_wr(8'h05, p);
      steps(3, 8, n);
      check("R6 wrong value idles", 8'(n), 8'd0);
      steps(0, 7, n);
      key_wr(8'hFF, p);
      check("R6 wrong last value", {7'd0, p}, 8'd0);
      key_wr(8'h7F, p);
      check("R6 no resume after miss", {7'd0, p}, 8'd0);
      key_wr(8'h01, p);
      steps(2, 8, n);
      check("R6 non-zero start", 8'(n), 8'd0);
   endtask

   task automatic t_read();
      int n, m;
      steps(0, 3, n);
      @(negedge clk);
      rd_en = 1'b1;
      #1;
      check("R7 read returns zero", rd_data, 8'h00);
      @(negedge clk);
      rd_en = 1'b0;
      steps(3, 8, m);
      check("R7 read does not disturb", 8'(m), 8'd1);
   endtask

   task automatic t_gap();
      logic p;
      int n;
      n = 0;
      for (int k = 0; k < 8; k++) begin
         key_wr(key_of(k), p);
         if (p) n++;
         repeat (20) @(negedge clk);
      end
      check("R8 idle gaps keep progress", 8'(n), 8'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_full();
      t_repeat();
      t_foreign();
      t_zero();
      t_wrong();
      t_read();
      t_gap();
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(negedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule